// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a simple clocked request port and an external 32K x 8 asynchronous static RAM. A single-cycle request carries a read/write flag, a 15-bit word address and, for writes, an 8-bit data byte. The controller then drives the memory's active-low select, write strobe and output strobe, a registered address bus and a data bus split into an output byte, a driver enable and an input byte. It returns a one-cycle completion pulse, and for reads it also returns the registered data byte.

Every phase length is a whole number of clock cycles. The counts are worked out at elaboration from a clock-period parameter and from the memory's nanosecond minimums, rounding up, with a floor of one cycle. Before the data drivers are enabled for a write that follows a read, the controller waits out the memory's output release time. This keeps the two sets of drivers from fighting on the shared bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, select, write strobe and output strobe are high (1), the data driver enable and the completion pulse are low (0), and the read data output is 8'h00.
- R2: The controller accepts a request only while idle. A request raised while a cycle is running does not change that cycle and does not start another one. When idle, all three strobes are high and the drivers are off.
- R3: A read drives select and output strobe low and holds write strobe high for RD_N+1 consecutive cycles, starting the cycle after the request. The drivers stay off throughout.
- R4: The read data output takes the memory input byte on the clock edge that ends the read. It shows that byte in the completion cycle and keeps it until the next read completes.
- R5: A write holds select low for AS_N+WP_N+WE_N cycles, starting the cycle after the request, or after the turnaround when there is one. Output strobe stays high and the drivers stay enabled for that whole span.
- R6: During a write, write strobe is low for exactly WP_N cycles, starting after AS_N cycles with it high. It rises while select is still low, and the output data byte does not change while it is low.
- R7: A write whose previous operation was a read spends TA_N cycles with every strobe high and the drivers off before select goes low. A write after a write gets no such wait.
- R8: The completion pulse lasts one cycle. It comes in the cycle right after the last phase of each operation, with select high and the drivers off.
- R9: Phase counts are ceil(ns / clock period), each at least 1. With an 8 ns clock and the default timing: RD_N = 9, the larger of the worst access time (70 ns) and the read cycle (70 ns) less one cycle. AS_N = 1 (0 ns setup). WP_N = 8, the largest of the 55 ns pulse, the 30 ns data setup, and the 65 ns address-to-strobe-rise and select-to-strobe-rise less AS_N. WE_N = 1, the remainder of the 70 ns write cycle. TA_N = 4 (25 ns release).
- R10: The address bus stays at the requested address while select is low. The data drivers are never enabled while the output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address of the request |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Registered byte from the last read |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 15 | Memory address bus |
| mem_cs_n_o | output | 1 | Memory select, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output strobe, active low |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe_o | output | 1 | Data driver enable, active high |
| mem_dq_i | input | 8 | Byte read from the data bus |

## Verification
The assertions assume that reset is applied before the first request and that the request fields are valid whenever req_i is high. They also rely on the memory input being sampled only on edges where the controller has a read in progress. The stimulus keeps each request to one cycle and sets the request fields just after a clock edge. Some requests are raised on purpose during a running cycle, to show that they are dropped. The bench's memory model returns inverted data until the access time has passed, so a read that samples too early returns wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_CAPTURE,
        PH_TURN,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_END
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   cs_n;
        logic   we_n;
        logic   oe_n;
        logic   dq_oe;
        logic   done;
        logic   last_rd;
    } ctl_t;

    // whole cycles covering a nanosecond minimum, never below one
    function automatic int ns2cyc(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] value_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_req_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          cap_rd_i,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_dq_o,
    output logic [DW-1:0] rdata_o
);

    logic [AW-1:0] addr_d, addr_q;
    logic [DW-1:0] wd_d, wd_q;
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        addr_d = addr_q;
        wd_d   = wd_q;
        rd_d   = rd_q;
        if (cap_req_i) begin
            addr_d = addr_i;
            wd_d   = wdata_i;
        end
        if (cap_rd_i) begin
            rd_d = mem_dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            addr_q <= addr_d;
            wd_q   <= wd_d;
            rd_q   <= rd_d;
        end
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = wd_q;
    assign rdata_o    = rd_q;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rd_i |=> $stable(rdata_o)); // R4

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW     = 15,
    parameter int DW     = 8,
    parameter int CLK_NS = 8,
    parameter int T_RC   = 70,
    parameter int T_AA   = 70,
    parameter int T_ACS  = 70,
    parameter int T_OE   = 35,
    parameter int T_HZ   = 25,
    parameter int T_WC   = 70,
    parameter int T_WP   = 55,
    parameter int T_AS   = 0,
    parameter int T_AW   = 65,
    parameter int T_CW   = 65,
    parameter int T_DW   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_cs_n_o,
    output logic          mem_we_n_o,
    output logic          mem_oe_n_o,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe_o,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int RD_N  = imax(ns2cyc(imax(imax(T_AA, T_ACS), T_OE), CLK_NS),
                                ns2cyc(T_RC, CLK_NS) - 1);
    localparam int AS_N  = ns2cyc(T_AS, CLK_NS);
    localparam int WP_N  = imax(imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DW, CLK_NS)),
                                imax(ns2cyc(T_AW, CLK_NS) - AS_N,
                                     ns2cyc(T_CW, CLK_NS) - AS_N));
    localparam int WE_N  = imax(1, ns2cyc(T_WC, CLK_NS) - AS_N - WP_N);
    localparam int TA_N  = ns2cyc(T_HZ, CLK_NS);
    localparam int MAX_N = imax(imax(RD_N, WP_N), imax(imax(AS_N, WE_N), TA_N));
    localparam int CW    = $clog2(MAX_N + 1);
    localparam int MW    = 16;

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cap_req;
    logic          cap_rd;

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .zero_o  (tmr_zero)
    );

    asram_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_req_i  (cap_req),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .cap_rd_i   (cap_rd),
        .mem_dq_i   (mem_dq_i),
        .mem_addr_o (mem_addr_o),
        .mem_dq_o   (mem_dq_o),
        .rdata_o    (rdata_o)
    );

    // next-state and strobe computation
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap_req    = 1'b0;
        cap_rd     = 1'b0;

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    cap_req  = 1'b1;
                    tmr_load = 1'b1;
                    if (!we_i) begin
                        ctl_d.ph = PH_RD_ACCESS;
                        tmr_val  = CW'(RD_N - 1);
                    end else if (ctl_q.last_rd) begin
                        ctl_d.ph = PH_TURN;
                        tmr_val  = CW'(TA_N - 1);
                    end else begin
                        ctl_d.ph = PH_WR_SETUP;
                        tmr_val  = CW'(AS_N - 1);
                    end
                end
            end
            PH_RD_ACCESS: begin
                if (tmr_zero) begin
                    ctl_d.ph = PH_RD_CAPTURE;
                end
            end
            PH_RD_CAPTURE: begin
                cap_rd        = 1'b1;
                ctl_d.ph      = PH_IDLE;
                ctl_d.done    = 1'b1;
                ctl_d.last_rd = 1'b1;
            end
            PH_TURN: begin
                if (tmr_zero) begin
                    ctl_d.ph      = PH_WR_SETUP;
                    ctl_d.last_rd = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = CW'(AS_N - 1);
                end
            end
            PH_WR_SETUP: begin
                if (tmr_zero) begin
                    ctl_d.ph = PH_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WP_N - 1);
                end
            end
            PH_WR_PULSE: begin
                if (tmr_zero) begin
                    ctl_d.ph = PH_WR_END;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WE_N - 1);
                end
            end
            PH_WR_END: begin
                if (tmr_zero) begin
                    ctl_d.ph      = PH_IDLE;
                    ctl_d.done    = 1'b1;
                    ctl_d.last_rd = 1'b0;
                end
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase

        // strobes are registered copies of the phase being entered
        ctl_d.cs_n  = !(ctl_d.ph inside {PH_RD_ACCESS, PH_RD_CAPTURE,
                                         PH_WR_SETUP, PH_WR_PULSE, PH_WR_END});
        ctl_d.oe_n  = !(ctl_d.ph inside {PH_RD_ACCESS, PH_RD_CAPTURE});
        ctl_d.we_n  = (ctl_d.ph != PH_WR_PULSE);
        ctl_d.dq_oe = (ctl_d.ph inside {PH_WR_SETUP, PH_WR_PULSE, PH_WR_END});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                       dq_oe: 1'b0, done: 1'b0, last_rd: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_cs_n_o  = ctl_q.cs_n;
    assign mem_we_n_o  = ctl_q.we_n;
    assign mem_oe_n_o  = ctl_q.oe_n;
    assign mem_dq_oe_o = ctl_q.dq_oe;
    assign done_o      = ctl_q.done;

    // window counters for the timing checks below
    logic [MW-1:0] we_run_q, hz_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q <= '0;
            hz_q     <= '1;
        end else begin
            we_run_q <= mem_we_n_o ? '0 : ((we_run_q == '1) ? we_run_q : we_run_q + 1'b1);
            hz_q     <= !mem_oe_n_o ? '0 : ((hz_q == '1) ? hz_q : hz_q + 1'b1);
        end
    end

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !mem_cs_n_o); // R6
    AST_WE_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> !mem_cs_n_o); // R6
    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_run_q >= MW'(WP_N))); // R9
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_dq_o)); // R6
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o); // R5
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o); // R10
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (hz_q >= MW'(TA_N))); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_cs_n_o && !mem_dq_oe_o)); // R8

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

    localparam int RD_N = 9, AS_N = 1, WP_N = 8, WE_N = 1, TA_N = 4;
    localparam int CLK_NS = 8, ACC_NS = 70;
    // pin vector {cs_n, we_n, oe_n, dq_oe, done}
    localparam logic [4:0] P_IDLE = 5'b11100, P_DONE = 5'b11101, P_RD = 5'b01000,
                           P_WH = 5'b01110, P_WL = 5'b00110;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, req_i, we_i, done_o;
    logic [14:0] addr_i, mem_addr_o;
    logic [7:0]  wdata_i, rdata_o, mem_dq_o, mem_dq_i;
    logic        mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
        .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
    );

    typedef struct {
        logic [4:0] pins;
        int         addr;
        int         wd;
        int         rd;
        bit         use_addr;
        bit         use_wd;
        bit         use_rd;
        string      tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  mem_m[int];
    logic [7:0]  gold[int];
    int          checks = 0, errors = 0, rd_age = 0;
    bit          last_rd = 1'b0;
    logic        p_cs = 1'b1, p_we = 1'b1;
    logic [14:0] p_addr = '0;
    logic [7:0]  p_dq = '0;

    function automatic logic [7:0] seed_val(int a);
        return 8'((a * 37 + 11) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] gold_val(int a);
        return gold.exists(a) ? gold[a] : seed_val(a);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(int n, logic [4:0] pins, int a, int d, bit ua, bit uw, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.pins = pins; e.addr = a; e.wd = d; e.rd = 0;
            e.use_addr = ua; e.use_wd = uw; e.use_rd = 1'b0; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // advance one clock, play the memory, compare against the expected cycle
    task automatic tick();
        exp_t e;
        logic [7:0] v;
        @(posedge clk);
        #1;
        if (!p_cs && !p_we && (mem_we_n_o || mem_cs_n_o)) mem_m[int'(p_addr)] = p_dq;
        if (!mem_cs_n_o && !mem_oe_n_o && mem_we_n_o) rd_age++; else rd_age = 0;
        v = mem_m.exists(int'(mem_addr_o)) ? mem_m[int'(mem_addr_o)] : seed_val(int'(mem_addr_o));
        mem_dq_i = (rd_age * CLK_NS >= ACC_NS) ? v : ~v;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
        end else begin
            e.pins = P_IDLE; e.addr = 0; e.wd = 0; e.rd = 0;
            e.use_addr = 0; e.use_wd = 0; e.use_rd = 0; e.tag = "R2";
        end
        chk({mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, done_o} == e.pins, e.tag,
            "strobes", {mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, done_o}, e.pins);
        if (e.use_addr) chk(int'(mem_addr_o) == e.addr, "R10", "addr", mem_addr_o, e.addr);
        if (e.use_wd) chk(int'(mem_dq_o) == e.wd, "R6", "wdata", mem_dq_o, e.wd);
        if (e.use_rd) chk(int'(rdata_o) == e.rd, "R4", "rdata", rdata_o, e.rd);
        p_cs = mem_cs_n_o; p_we = mem_we_n_o; p_addr = mem_addr_o; p_dq = mem_dq_o;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) tick();
    endtask

    task automatic do_read(int a, bit poke);
        exp_t e;
        req_i = 1'b1; we_i = 1'b0; addr_i = 15'(a); wdata_i = 8'h00;
        push(RD_N + 1, P_RD, a, 0, 1, 0, "R3");
        e.pins = P_DONE; e.addr = 0; e.wd = 0; e.rd = int'(gold_val(a));
        e.use_addr = 0; e.use_wd = 0; e.use_rd = 1; e.tag = "R8";
        exp_q.push_back(e);
        tick();
        req_i = 1'b0;
        if (poke) begin
            req_i = 1'b1; we_i = 1'b1; addr_i = 15'(a ^ 'h0F0F); wdata_i = 8'hC3;
            tick();
            req_i = 1'b0;
        end
        drain();
        last_rd = 1'b1;
    endtask

    task automatic do_write(int a, int d, bit poke);
        req_i = 1'b1; we_i = 1'b1; addr_i = 15'(a); wdata_i = 8'(d);
        if (last_rd) push(TA_N, P_IDLE, 0, 0, 0, 0, "R7");
        push(AS_N, P_WH, a, d, 1, 1, "R5");
        push(WP_N, P_WL, a, d, 1, 1, "R9");
        push(WE_N, P_WH, a, d, 1, 1, "R5");
        push(1, P_DONE, 0, 0, 0, 0, "R8");
        gold[a] = 8'(d);
        tick();
        req_i = 1'b0;
        if (poke) begin
            req_i = 1'b1; we_i = 1'b0; addr_i = 15'(a + 1);
            tick();
            req_i = 1'b0;
        end
        drain();
        last_rd = 1'b0;
    endtask

    initial begin
        int lcg;
        rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
        mem_dq_i = 8'hEE;
        push(4, P_IDLE, 0, 0, 0, 0, "R1");
        repeat (4) tick();
        chk(rdata_o == 8'h00, "R1", "rdata reset", rdata_o, 0);
        rst_n = 1'b1;
        push(1, P_IDLE, 0, 0, 0, 0, "R1");
        repeat (3) tick();

        do_read('h0000, 0);
        do_write('h1234, 'hA5, 0);
        do_write('h7FFF, 'h3C, 0);
        do_read('h1234, 0);
        do_read('h7FFF, 0);
        do_write('h0000, 'h5A, 1);
        do_read('h0000, 1);
        repeat (5) tick();
        do_write('h0100, 'h81, 0);
        do_read('h0100, 0);

        lcg = 12345;
        for (int i = 0; i < 40; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
            if (lcg[3]) do_write((lcg >> 8) & 'h1F, (lcg >> 16) & 'hFF, 1'(lcg[4]));
            else        do_read((lcg >> 8) & 'h1F, 1'(lcg[5]));
            if (lcg[6]) tick();
        end
        repeat (4) tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule